// File: doc/BRIEF.md
# Multi-Channel Serial DAC Refresh Driver

This block keeps one setting for each of up to eight channels of an external 8-bit voltage DAC. It sends the settings out over a three-wire serial link: a serial clock, a data line and a frame strobe. A processor writes each setting through a small parallel register port. The setting holds an 8-bit code and a span-select bit.

An internal tick divider fires at a fixed sample rate. On every tick, the channels picked by an enable mask are sent one after another, lowest address first. All the selected outputs therefore settle within a short window of each other.

Each frame is 12 bits long. The frame strobe goes high before the serial clock starts. Data moves on the rising clock edge, so the DAC can take each bit on the falling edge. The strobe goes low half a serial period after the last falling edge. The processor can read back a busy bit. It can also read a sticky overrun bit, which shows that a pass of frames did not finish before the next tick.

Top module: `sdac_refresh_ctrl`

## Requirements
- R1: Each frame is framed by `dac_load` high. `dac_sclk` rises only while `dac_load` has been high for at least one cycle. Exactly 12 rising edges of `dac_sclk` occur in each high window of `dac_load`.
- R2: Frame bits go out MSB first in this order: channel address bits 2..0, then the range bit, then code bits 7..0.
- R3: A write to `bus_addr` 0..7 stores `bus_wdata[8]` as that channel's range bit and `bus_wdata[7:0]` as its code. A read of the same address returns them in `bus_rdata[8:0]`. The frame for that channel carries these values.
- R4: `dac_sdo` changes only on a rising edge of `dac_sclk` and is stable on each falling edge.
- R5: While framed, each high phase and each low phase of `dac_sclk` lasts SCLK_HALF clocks. The first rise comes SCLK_HALF clocks after `dac_load` rises. `dac_load` falls SCLK_HALF clocks after the last fall. `dac_sclk` is low whenever `dac_load` is low.
- R6: A tick occurs every TICK_DIV clocks. On each tick, the channels whose bit is set in the mask register (`bus_addr` 8, bit n = channel n) are sent back to back in ascending address order. A mask of zero sends nothing.
- R7: Status bit 0 (`bus_addr` 9) reads 1 while any frame of a pass is pending or in flight, and reads 0 otherwise.
- R8: A channel write made while a frame is in flight does not alter that frame. The new value is sent on the next pass.
- R9: Status bit 1 is set when a tick arrives before the previous pass has finished. It stays set until a write to `bus_addr` 9 with `bus_wdata[1]` = 1. A mask whose pass fits within TICK_DIV never sets it.
- R10: After reset, `dac_sclk`, `dac_load` and `dac_sdo` are low, and the mask, all channel registers and the status read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address (0..7 channels, 8 mask, 9 status) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| dac_sclk | output | 1 | Serial clock to the DAC |
| dac_load | output | 1 | Frame strobe, high for the length of a frame |
| dac_sdo | output | 1 | Serial data to the DAC |

## Verification
The checker watches the serial line on every cycle. It checks the framing order of strobe and clock, the count of 12 rising edges per frame, data stability across falling edges, the exact width of each clock phase, and that the overrun bit stays set until it is cleared. The things it cannot see are checked by the bench's scenarios. These are the bit contents and order of each frame, the ascending channel order within a pass, the spacing between ticks, how a channel write made during a frame is handled, the busy bit, and whether overrun is set or stays clear for passes just under and just over the tick period.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
   localparam int CH_ADDR_W = 3;
   localparam int CODE_W    = 8;
   localparam int FRAME_W   = CH_ADDR_W + 1 + CODE_W;
   localparam int BUS_AW    = 4;
   localparam int BUS_DW    = 16;
   localparam logic [BUS_AW-1:0] MASK_ADDR = 4'd8;
   localparam logic [BUS_AW-1:0] STAT_ADDR = 4'd9;

   typedef struct packed {
      logic              rng;
      logic [CODE_W-1:0] code;
   } chan_word_t;

   typedef logic [FRAME_W-1:0] frame_t;
endpackage

// File: rtl/sdac_tick_gen.sv
module sdac_tick_gen #(
   parameter int TICK_DIV = 25000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICK_DIV - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         tick  <= 1'b0;
      end else begin
         tick <= (cnt_q == CNT_LAST);
         if (cnt_q == CNT_LAST) cnt_q <= '0;
         else                   cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/sdac_chan_seq.sv
module sdac_chan_seq
   import sdac_pkg::*;
#(
   parameter int NUM_CH = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          tick,
   input  logic [NUM_CH-1:0]             en_mask,
   input  chan_word_t [NUM_CH-1:0]       ch_words,
   input  logic                          ser_busy,
   input  logic                          ovr_clr,
   output logic                          start,
   output frame_t                        frame,
   output logic                          pass_busy,
   output logic                          ovr_flag
);
   logic [NUM_CH-1:0]    pend_q;
   logic [CH_ADDR_W-1:0] sel;
   logic                 any_pend;

   assign any_pend = |pend_q;

   always_comb begin
      sel = '0;
      for (int i = NUM_CH - 1; i >= 0; i--) begin
         if (pend_q[i]) sel = CH_ADDR_W'(i);
      end
   end

   assign start     = any_pend && !ser_busy && !tick;
   assign frame     = {sel, ch_words[sel].rng, ch_words[sel].code};
   assign pass_busy = any_pend || ser_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q   <= '0;
         ovr_flag <= 1'b0;
      end else begin
         if (tick) begin
            pend_q <= en_mask;
         end else if (start) begin
            pend_q[sel] <= 1'b0;
         end
         if (tick && (any_pend || ser_busy)) ovr_flag <= 1'b1;
         else if (ovr_clr)                   ovr_flag <= 1'b0;
      end
   end
endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter
   import sdac_pkg::*;
#(
   parameter int SCLK_HALF = 4
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start,
   input  frame_t frame,
   output logic   busy,
   output logic   sclk,
   output logic   load,
   output logic   sdo
);
   localparam int PH_W    = $clog2(2 * FRAME_W + 2);
   localparam logic [PH_W-1:0] PH_LAST_BIT = PH_W'(2 * FRAME_W);
   localparam logic [PH_W-1:0] PH_GAP      = PH_W'(2 * FRAME_W + 1);

   logic [PH_W-1:0] phase_q;
   frame_t          shreg_q;
   logic            half_done;

   generate
      if (SCLK_HALF == 1) begin : g_nodiv
         assign half_done = 1'b1;
      end else begin : g_div
         localparam int HC_W = $clog2(SCLK_HALF);
         logic [HC_W-1:0] hcnt_q;
         assign half_done = (hcnt_q == HC_W'(SCLK_HALF - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 hcnt_q <= '0;
            else if (!busy || half_done) hcnt_q <= '0;
            else                        hcnt_q <= hcnt_q + 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         sclk    <= 1'b0;
         load    <= 1'b0;
         sdo     <= 1'b0;
         phase_q <= '0;
         shreg_q <= '0;
      end else if (!busy) begin
         if (start) begin
            busy    <= 1'b1;
            load    <= 1'b1;
            sclk    <= 1'b0;
            phase_q <= '0;
            shreg_q <= frame;
         end
      end else if (half_done) begin
         if (phase_q == PH_GAP) begin
            busy <= 1'b0;
            sdo  <= 1'b0;
         end else begin
            phase_q <= phase_q + 1'b1;
            if (phase_q == PH_LAST_BIT) begin
               load <= 1'b0;
            end else if (!phase_q[0]) begin
               sclk    <= 1'b1;
               sdo     <= shreg_q[FRAME_W-1];
               shreg_q <= {shreg_q[FRAME_W-2:0], 1'b0};
            end else begin
               sclk <= 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/sdac_refresh_ctrl.sv
module sdac_refresh_ctrl
   import sdac_pkg::*;
#(
   parameter int NUM_CH    = 8,
   parameter int TICK_DIV  = 25000,
   parameter int SCLK_HALF = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [3:0]        bus_addr,
   input  logic [15:0]       bus_wdata,
   output logic [15:0]       bus_rdata,
   output logic              dac_sclk,
   output logic              dac_load,
   output logic              dac_sdo
);
   generate
      if (NUM_CH < 1 || NUM_CH > 8) begin : g_bad_ch
         $error("NUM_CH must lie in 1..8");
      end
      if (SCLK_HALF < 1) begin : g_bad_half
         $error("SCLK_HALF must be at least 1");
      end
      if (TICK_DIV < 2) begin : g_bad_tick
         $error("TICK_DIV must be at least 2");
      end
   endgenerate

   chan_word_t [NUM_CH-1:0] ch_q;
   logic [NUM_CH-1:0]       mask_q;
   logic                    tick, start, ser_busy, pass_busy, ovr_flag, ovr_clr;
   frame_t                  frame;

   genvar g;
   generate
      for (g = 0; g < NUM_CH; g++) begin : g_chreg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ch_q[g] <= '0;
            else if (bus_wr && bus_addr == BUS_AW'(g))
               ch_q[g] <= chan_word_t'(bus_wdata[CODE_W:0]);
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q <= '0;
      else if (bus_wr && bus_addr == MASK_ADDR) mask_q <= bus_wdata[NUM_CH-1:0];
   end

   assign ovr_clr = bus_wr && (bus_addr == STAT_ADDR) && bus_wdata[1];

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == MASK_ADDR)      bus_rdata[NUM_CH-1:0] = mask_q;
      else if (bus_addr == STAT_ADDR) bus_rdata[1:0] = {ovr_flag, pass_busy};
      else begin
         for (int i = 0; i < NUM_CH; i++) begin
            if (bus_addr == BUS_AW'(i)) bus_rdata[CODE_W:0] = ch_q[i];
         end
      end
   end

   sdac_tick_gen #(.TICK_DIV(TICK_DIV)) tick_i (
      .clk(clk), .rst_n(rst_n), .tick(tick));

   sdac_chan_seq #(.NUM_CH(NUM_CH)) seq_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .en_mask(mask_q),
      .ch_words(ch_q), .ser_busy(ser_busy), .ovr_clr(ovr_clr),
      .start(start), .frame(frame), .pass_busy(pass_busy), .ovr_flag(ovr_flag));

   sdac_shifter #(.SCLK_HALF(SCLK_HALF)) shf_i (
      .clk(clk), .rst_n(rst_n), .start(start), .frame(frame),
      .busy(ser_busy), .sclk(dac_sclk), .load(dac_load), .sdo(dac_sdo));
endmodule

// File: rtl/sdac_refresh_chk.sv
module sdac_refresh_chk #(
   parameter int SCLK_HALF = 4
) (
   input logic        clk,
   input logic        rst_n,
   input logic        sclk,
   input logic        load,
   input logic        sdo,
   input logic        bus_wr,
   input logic [3:0]  bus_addr,
   input logic [15:0] bus_wdata,
   input logic        ovr
);
   logic [15:0] hi_len, lo_len;
   logic [4:0]  rise_cnt;
   logic        sclk_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_len   <= '0;
         lo_len   <= '0;
         rise_cnt <= '0;
         sclk_d   <= 1'b0;
      end else begin
         sclk_d <= sclk;
         if (sclk && hi_len != 16'hFFFF) hi_len <= hi_len + 1'b1;
         else if (!sclk)                 hi_len <= '0;
         if (!load || sclk)             lo_len <= '0;
         else if (lo_len != 16'hFFFF)   lo_len <= lo_len + 1'b1;
         if (!load)                     rise_cnt <= '0;
         else if (sclk && !sclk_d)      rise_cnt <= rise_cnt + 1'b1;
      end
   end

   p_clock_inside_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk) |-> load && $past(load));
   p_twelve_rises_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(load) |-> rise_cnt == 5'd12);
   p_sdo_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !$rose(sclk)) |-> $stable(sdo));
   p_sclk_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !load |-> !sclk);
   p_high_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sclk) |-> hi_len == 16'(SCLK_HALF));
   p_low_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk) |-> lo_len == 16'(SCLK_HALF));
   p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr && !(bus_wr && bus_addr == 4'd9 && bus_wdata[1])) |=> ovr);
endmodule

bind sdac_refresh_ctrl sdac_refresh_chk #(.SCLK_HALF(SCLK_HALF)) chk_i (
   .clk(clk), .rst_n(rst_n), .sclk(dac_sclk), .load(dac_load), .sdo(dac_sdo),
   .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .ovr(ovr_flag));

// File: tb/sdac_refresh_ctrl_tb_top.sv
`timescale 1ns/1ps
module sdac_refresh_ctrl_tb_top;
   localparam int NCH  = 8;
   localparam int TDIV = 400;
   localparam int HALF = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        dac_sclk, dac_load, dac_sdo;

   int vec = 0;
   int bad = 0;
   longint cyc = 0;

   logic [11:0] pass_q[$];
   logic [11:0] rx_q[$];
   longint      rx_t[$];
   int          pidx = 0;
   int          pseen = 0;
   logic [8:0]  shadow [NCH];

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   sdac_refresh_ctrl #(.NUM_CH(NCH), .TICK_DIV(TDIV), .SCLK_HALF(HALF)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dac_sclk(dac_sclk),
      .dac_load(dac_load), .dac_sdo(dac_sdo));

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      vec++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // monitor: rebuild frames from the serial line, compare with the expected pass
   logic        p_load = 1'b0, p_sclk = 1'b0;
   logic [11:0] m_frm;
   int          m_bits;
   longint      t_rise, t_first, t_lastfall;
   always @(negedge clk) begin
      if (rst_n) begin
         if (dac_load && !p_load) begin
            m_bits = 0; m_frm = '0; t_rise = cyc; t_first = -1;
         end
         if (dac_sclk && !p_sclk && t_first < 0) t_first = cyc;
         if (!dac_sclk && p_sclk && dac_load) begin
            m_frm = {m_frm[10:0], dac_sdo};
            m_bits++;
            t_lastfall = cyc;
         end
         if (!dac_load && p_load) begin
            chk(m_bits == 12, "R1 bits per frame", m_bits, 12);
            chk(t_first - t_rise == HALF, "R5 load-to-first-rise", t_first - t_rise, HALF);
            chk(cyc - t_lastfall == HALF, "R5 last-fall-to-load-low", cyc - t_lastfall, HALF);
            rx_q.push_back(m_frm);
            rx_t.push_back(t_rise);
            if (pass_q.size() > 0) begin
               chk(m_frm == pass_q[pidx], "R2/R6 frame order and content", m_frm, pass_q[pidx]);
               pidx = (pidx + 1) % pass_q.size();
               pseen++;
            end
         end
      end
      p_load = dac_load;
      p_sclk = dac_sclk;
   end

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [15:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic drain();
      logic [15:0] s;
      do rd(4'd9, s); while (s[0]);
      repeat (4 * HALF) @(negedge clk);
   endtask

   // driver: load the expected pass into the scoreboard and run it
   task automatic run_pass(input logic [7:0] mask, input string req);
      logic [15:0] s;
      int n;
      pass_q.delete(); pidx = 0; pseen = 0;
      for (int c = 0; c < NCH; c++)
         if (mask[c]) pass_q.push_back({3'(c), shadow[c]});
      n = pass_q.size();
      wr(4'd8, {8'h00, mask});
      @(posedge dac_load);
      rd(4'd9, s);
      chk(s[0] == 1'b1, "R7 busy during pass", s[0], 1);
      repeat (3 * TDIV) @(negedge clk);
      wr(4'd8, 16'h0);
      drain();
      rd(4'd9, s);
      chk(s[0] == 1'b0, "R7 busy clear after drain", s[0], 0);
      chk(s[1] == 1'b0, "R9 no overrun when pass fits", s[1], 0);
      chk(pidx == 0 && pseen >= 2 * n, {req, " whole passes"}, pseen, 2 * n);
      pass_q.delete();
   endtask

   initial begin
      logic [15:0] d;
      logic [8:0] codes [NCH];
      codes = '{9'h000, 9'h1FF, 9'h05A, 9'h1A5, 9'h001, 9'h180, 9'h03C, 9'h1C3};
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk({dac_sclk, dac_load, dac_sdo} == 3'b000, "R10 serial lines low", {dac_sclk, dac_load, dac_sdo}, 0);
      rd(4'd9, d); chk(d == 16'h0, "R10 status", d, 0);
      rd(4'd8, d); chk(d == 16'h0, "R10 mask", d, 0);
      for (int c = 0; c < NCH; c++) begin
         rd(4'(c), d); chk(d == 16'h0, "R10 channel reg", d, 0);
      end
      // R3 write and readback, codes 0x00/0xFF and both ranges
      for (int c = 0; c < NCH; c++) begin
         shadow[c] = codes[c];
         wr(4'(c), {7'h0, codes[c]});
      end
      for (int c = 0; c < NCH; c++) begin
         rd(4'(c), d); chk(d == {7'h0, shadow[c]}, "R3 readback", d, shadow[c]);
      end
      // R2 R3 R6 sparse and near-full masks, R9 boundary with 7 channels
      run_pass(8'hA5, "R6 mask A5");
      run_pass(8'h7F, "R6 mask 7F");
      // R6 tick spacing with one channel
      rx_q.delete(); rx_t.delete();
      wr(4'd8, 16'h0001);
      repeat (4 * TDIV) @(negedge clk);
      wr(4'd8, 16'h0); drain();
      chk(rx_t.size() >= 3, "R6 frame per tick", rx_t.size(), 3);
      for (int k = 1; k < rx_t.size(); k++)
         chk(rx_t[k] - rx_t[k-1] == TDIV, "R6 tick period", rx_t[k] - rx_t[k-1], TDIV);
      // R8 write during an in-flight frame
      rx_q.delete();
      wr(4'd8, 16'h0008);
      @(posedge dac_load);
      @(negedge clk);
      wr(4'd3, 16'h0077);
      repeat (3 * TDIV) @(negedge clk);
      wr(4'd8, 16'h0); drain();
      chk(rx_q.size() >= 2, "R8 frames seen", rx_q.size(), 2);
      if (rx_q.size() >= 2) begin
         chk(rx_q[0] == {3'd3, shadow[3]}, "R8 in-flight frame unchanged", rx_q[0], {3'd3, shadow[3]});
         chk(rx_q[1] == 12'h677, "R8 new value next pass", rx_q[1], 12'h677);
      end
      shadow[3] = 9'h077;
      // R9 overrun with all eight channels
      wr(4'd8, 16'h00FF);
      repeat (3 * TDIV) @(negedge clk);
      rd(4'd9, d); chk(d[1] == 1'b1, "R9 overrun set", d[1], 1);
      wr(4'd8, 16'h0); drain();
      repeat (2 * TDIV) @(negedge clk);
      rd(4'd9, d); chk(d[1] == 1'b1, "R9 overrun sticky", d[1], 1);
      wr(4'd9, 16'h0002);
      rd(4'd9, d); chk(d[1] == 1'b0, "R9 overrun cleared", d[1], 0);
      // R6 zero mask sends nothing
      rx_q.delete();
      repeat (3 * TDIV) @(negedge clk);
      chk(rx_q.size() == 0, "R6 zero mask idle", rx_q.size(), 0);
      chk(dac_load == 1'b0, "R6 load stays low", dac_load, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
   end
endmodule